// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block holds three 32-bit registers behind a word-addressed read/write port: a control register, an interrupt event register, and an interrupt mask register. Software never modifies them with a read-modify-write. Each register has two addresses. A write to the set address turns on every bit written as 1. A write to the clear address turns off every bit written as 1. Bits written as 0 keep their value in both cases.

Hardware raises event bits with single-cycle pulses on `evt_pulse_i`. The interrupt line is high whenever an event bit and its mask bit are both 1. Reading the event register through its clear address returns only the unmasked events that are active, so a handler can see them in one read.

The block has two resets. The global reset clears every bit. The soft reset clears the event register, the mask register and most of the control register. It leaves alone a group of control bits chosen by the `STICKY` parameter.

The bus pins are plain strobes with no back-pressure. A write takes effect on the edge at which `wr_en_i` is high. Read data appears on the cycle after `rd_en_i` and holds until the next read.

Top module: `scb_bank`

## Requirements
- R1: A write to a set address ORs the write data into that register.
- R2: A write to a clear address clears every register bit whose data bit is 1 and leaves the rest unchanged.
- R3: A read returns the register value from before that edge on `rd_data_o` one cycle after `rd_en_i`, and holds it until the next read. The control register and mask register read the same through both of their addresses. The event register reads raw through its set address.
- R4: A read of the event clear address returns the event bits ANDed with the mask bits.
- R5: The byte addresses are: control set 0x50, control clear 0x54, event set 0x80, event clear 0x84, mask set 0x88, mask clear 0x8C.
- R6: While `grst_ni` is low, all three registers and `rd_data_o` are 0. A soft reset cycle clears the event register, the mask register, and the control bits outside `STICKY` (default 0xF0000000). It keeps the control bits inside `STICKY`.
- R7: A 1 on `evt_pulse_i` sets that event bit. A pulse and a clear write to the same bit in the same cycle leave the bit at 1.
- R8: `irq_o` is high in exactly the cycles in which (event AND mask) is nonzero.
- R9: Reads of any other address return 0. Writes to any other address change no register.
- R10: In a soft reset cycle, soft reset takes priority over writes and event pulses in that same cycle.
- R11: The word index is taken from `addr_i[10:2]`. Bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| grst_ni | input | 1 | Global reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset, synchronous, active high |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 11 | Byte address within the 2 KB window |
| wr_data_i | input | 32 | Write data |
| evt_pulse_i | input | 32 | Hardware event pulses, one per event bit |
| rd_data_o | output | 32 | Registered read data |
| ctl_o | output | 32 | Current control register value |
| irq_o | output | 1 | Interrupt: any unmasked event bit is set |

## Verification
Two functions can land on the same event bit in the same cycle.

- **Pulse against clear write.** The bench drives a hardware pulse on a bit while it writes the event clear address with that same bit. The expected result is that the bit ends at 1. The same stimulus also runs on a second bit, where only the write is present, and that bit must clear.
- **Soft reset against write and pulse.** The bench raises soft reset in the same cycle as an event write and a pulse. The expected result is that soft reset wins.

In both cases a behavioural model runs beside the design. The bench compares `ctl_o`, `irq_o` and every read result against the model on each clock.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned CTL_SET_BYTE = 32'h50;
  localparam int unsigned CTL_CLR_BYTE = 32'h54;
  localparam int unsigned EVT_SET_BYTE = 32'h80;
  localparam int unsigned EVT_CLR_BYTE = 32'h84;
  localparam int unsigned MSK_SET_BYTE = 32'h88;
  localparam int unsigned MSK_CLR_BYTE = 32'h8C;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_CTL_SET = 3'd1,
    SEL_CTL_CLR = 3'd2,
    SEL_EVT_SET = 3'd3,
    SEL_EVT_CLR = 3'd4,
    SEL_MSK_SET = 3'd5,
    SEL_MSK_CLR = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lo;

  assign idx       = addr_i[ADDR_W-1:2];
  assign unused_lo = ^addr_i[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if      (idx == IDX_W'(CTL_SET_BYTE >> 2)) sel_o = SEL_CTL_SET;
    else if (idx == IDX_W'(CTL_CLR_BYTE >> 2)) sel_o = SEL_CTL_CLR;
    else if (idx == IDX_W'(EVT_SET_BYTE >> 2)) sel_o = SEL_EVT_SET;
    else if (idx == IDX_W'(EVT_CLR_BYTE >> 2)) sel_o = SEL_EVT_CLR;
    else if (idx == IDX_W'(MSK_SET_BYTE >> 2)) sel_o = SEL_MSK_SET;
    else if (idx == IDX_W'(MSK_CLR_BYTE >> 2)) sel_o = SEL_MSK_CLR;
  end
endmodule

// File: rtl/scb_sc_reg.sv
module scb_sc_reg #(
  parameter int           W         = 32,
  parameter logic [W-1:0] SOFT_KEEP = '0
) (
  input  logic         clk_i,
  input  logic         grst_ni,
  input  logic         soft_rst_i,
  input  logic         set_stb_i,
  input  logic         clr_stb_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m, clr_m, nxt;

  always_comb begin
    set_m = set_stb_i ? wdata_i : '0;
    clr_m = clr_stb_i ? wdata_i : '0;
    if (soft_rst_i) nxt = q_o & SOFT_KEEP;
    else            nxt = ((q_o | set_m) & ~clr_m) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge grst_ni) begin
    if (!grst_ni) q_o <= '0;
    else          q_o <= nxt;
  end
endmodule

// File: rtl/scb_rdmux.sv
module scb_rdmux
  import scb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         grst_ni,
  input  logic         rd_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] ctl_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] msk_i,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0] rd_nxt;

  always_comb begin
    unique case (sel_i)
      SEL_CTL_SET, SEL_CTL_CLR: rd_nxt = ctl_i;
      SEL_EVT_SET:              rd_nxt = evt_i;
      SEL_EVT_CLR:              rd_nxt = evt_i & msk_i;
      SEL_MSK_SET, SEL_MSK_CLR: rd_nxt = msk_i;
      default:                  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge grst_ni) begin
    if (!grst_ni)     rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_nxt;
  end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
  import scb_pkg::*;
#(
  parameter int               ADDR_W = 11,
  parameter int               DATA_W = 32,
  parameter logic [DATA_W-1:0] STICKY = 32'hF000_0000
) (
  input  logic              clk_i,
  input  logic              grst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] evt_pulse_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctl_q, evt_q, msk_q;

  scb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  scb_sc_reg #(.W(DATA_W), .SOFT_KEEP(STICKY)) u_ctl (
    .clk_i      (clk_i),
    .grst_ni    (grst_ni),
    .soft_rst_i (soft_rst_i),
    .set_stb_i  (wr_en_i && sel == SEL_CTL_SET),
    .clr_stb_i  (wr_en_i && sel == SEL_CTL_CLR),
    .wdata_i    (wr_data_i),
    .hw_set_i   ('0),
    .q_o        (ctl_q)
  );

  scb_sc_reg #(.W(DATA_W), .SOFT_KEEP('0)) u_evt (
    .clk_i      (clk_i),
    .grst_ni    (grst_ni),
    .soft_rst_i (soft_rst_i),
    .set_stb_i  (wr_en_i && sel == SEL_EVT_SET),
    .clr_stb_i  (wr_en_i && sel == SEL_EVT_CLR),
    .wdata_i    (wr_data_i),
    .hw_set_i   (evt_pulse_i),
    .q_o        (evt_q)
  );

  scb_sc_reg #(.W(DATA_W), .SOFT_KEEP('0)) u_msk (
    .clk_i      (clk_i),
    .grst_ni    (grst_ni),
    .soft_rst_i (soft_rst_i),
    .set_stb_i  (wr_en_i && sel == SEL_MSK_SET),
    .clr_stb_i  (wr_en_i && sel == SEL_MSK_CLR),
    .wdata_i    (wr_data_i),
    .hw_set_i   ('0),
    .q_o        (msk_q)
  );

  scb_rdmux #(.W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .grst_ni   (grst_ni),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel),
    .ctl_i     (ctl_q),
    .evt_i     (evt_q),
    .msk_i     (msk_q),
    .rd_data_o (rd_data_o)
  );

  assign ctl_o = ctl_q;
  assign irq_o = |(evt_q & msk_q);
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk #(
  parameter int                ADDR_W = 11,
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] STICKY = 32'hF000_0000
) (
  input logic              clk_i,
  input logic              grst_ni,
  input logic              soft_rst_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] evt_pulse_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] ctl_q,
  input logic [DATA_W-1:0] evt_q,
  input logic [DATA_W-1:0] msk_q
);
  logic [ADDR_W-3:0] widx;
  logic              mapped;

  assign widx   = addr_i[ADDR_W-1:2];
  assign mapped = (widx == 'h14) || (widx == 'h15) || (widx == 'h20) ||
                  (widx == 'h21) || (widx == 'h22) || (widx == 'h23);

  p_ctl_set_r1: assert property (@(posedge clk_i) disable iff (!grst_ni)
    (wr_en_i && !soft_rst_i && widx == 'h14) |=> ((ctl_q & $past(wr_data_i)) == $past(wr_data_i)));

  p_ctl_clr_r2: assert property (@(posedge clk_i) disable iff (!grst_ni)
    (wr_en_i && !soft_rst_i && widx == 'h15) |=> ((ctl_q & $past(wr_data_i)) == '0));

  p_evt_masked_rd_r4: assert property (@(posedge clk_i) disable iff (!grst_ni)
    (rd_en_i && widx == 'h21) |=> ((rd_data_o & ~$past(msk_q)) == '0));

  p_soft_rst_r6: assert property (@(posedge clk_i) disable iff (!grst_ni)
    soft_rst_i |=> (evt_q == '0 && msk_q == '0 && (ctl_q & ~STICKY) == '0));

  p_pulse_wins_r7: assert property (@(posedge clk_i) disable iff (!grst_ni)
    (!soft_rst_i && evt_pulse_i != '0) |=> ((evt_q & $past(evt_pulse_i)) == $past(evt_pulse_i)));

  p_unmapped_rd_r9: assert property (@(posedge clk_i) disable iff (!grst_ni)
    (rd_en_i && !mapped) |=> (rd_data_o == '0));
endmodule

bind scb_bank scb_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STICKY(STICKY)) i_chk (
  .clk_i       (clk_i),
  .grst_ni     (grst_ni),
  .soft_rst_i  (soft_rst_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wr_data_i   (wr_data_i),
  .evt_pulse_i (evt_pulse_i),
  .rd_data_o   (rd_data_o),
  .ctl_q       (ctl_q),
  .evt_q       (evt_q),
  .msk_q       (msk_q)
);

// File: tb/test_scb_bank.sv
module test_scb_bank;
  localparam logic [31:0] STICKY = 32'hF000_0000;

  logic        clk = 1'b0;
  logic        grst_n = 1'b0;
  logic        srst = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] pulse = '0;
  logic [31:0] rd_data, ctl;
  logic        irq;

  int    total = 0;
  int    bad = 0;
  string tag = "R6";
  bit    done = 0;

  logic [31:0] m_ctl = '0, m_evt = '0, m_msk = '0, m_rd = '0;
  bit          m_rdv = 0;

  always #5 clk = ~clk;

  scb_bank #(.STICKY(STICKY)) i_scb_bank (
    .clk_i(clk), .grst_ni(grst_n), .soft_rst_i(srst), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wr_data_i(wd), .evt_pulse_i(pulse),
    .rd_data_o(rd_data), .ctl_o(ctl), .irq_o(irq)
  );

  function automatic logic [31:0] ref_read(int w);
    case (w)
      'h14, 'h15: return m_ctl;
      'h20:       return m_evt;
      'h21:       return m_evt & m_msk;
      'h22, 'h23: return m_msk;
      default:    return 32'h0;
    endcase
  endfunction

  // Reference model, updated on every rising edge
  always @(posedge clk) begin
    int w;
    w = int'(addr[10:2]);
    if (!grst_n) begin
      m_ctl = '0; m_evt = '0; m_msk = '0; m_rd = '0; m_rdv = 0;
    end else begin
      m_rdv = re;
      if (re) m_rd = ref_read(w);
      if (srst) begin
        m_ctl = m_ctl & STICKY; m_evt = '0; m_msk = '0;
      end else begin
        if (we) begin
          case (w)
            'h14: m_ctl = m_ctl | wd;
            'h15: m_ctl = m_ctl & ~wd;
            'h20: m_evt = m_evt | wd;
            'h21: m_evt = m_evt & ~wd;
            'h22: m_msk = m_msk | wd;
            'h23: m_msk = m_msk & ~wd;
            default: ;
          endcase
        end
        m_evt = m_evt | pulse;
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // Comparison on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk({tag, " ctl_o"}, ctl, m_ctl);
      chk("R8 irq_o", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
      if (m_rdv || !grst_n) chk({tag, " rd_data_o"}, rd_data, m_rd);
    end
  end

  task automatic cyc(bit w, bit r, logic [10:0] a, logic [31:0] d, logic [31:0] p, bit s);
    @(negedge clk); #1;
    we = w; re = r; addr = a; wd = d; pulse = p; srst = s;
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, '0, 0);
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d);
    cyc(1, 0, a, d, '0, 0);
  endtask

  task automatic rd(logic [10:0] a);
    cyc(0, 1, a, '0, '0, 0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    #1 grst_n = 1'b1;
    idle();
    rd(11'h050); rd(11'h054); rd(11'h080); rd(11'h084); rd(11'h088); rd(11'h08C);

    tag = "R1";
    wr(11'h050, 32'h0000_00A5);
    wr(11'h050, 32'h0F00_0000);
    idle();
    tag = "R3"; rd(11'h050); rd(11'h054);

    tag = "R2";
    wr(11'h054, 32'h0000_0005);
    idle(); rd(11'h050);

    // R5 mapping, R4 masked read, R8
    tag = "R5";
    wr(11'h088, 32'h0000_00F0);
    wr(11'h080, 32'h0000_0033);
    idle();
    tag = "R4"; rd(11'h084);
    tag = "R3"; rd(11'h080); rd(11'h08C);

    tag = "R11";
    wr(11'h053, 32'h0000_1000);
    wr(11'h089, 32'h0000_0001);
    rd(11'h052); rd(11'h08B);

    // R7: pulse on bit 8 against clear of bits 8 and 4
    tag = "R7";
    cyc(1, 0, 11'h084, 32'h0000_0110, 32'h0000_0100, 0);
    cyc(0, 0, '0, '0, 32'h0000_0004, 0);
    idle(); rd(11'h080);

    tag = "R9";
    wr(11'h058, 32'hFFFF_FFFF);
    wr(11'h040, 32'hFFFF_FFFF);
    wr(11'h7FC, 32'hFFFF_FFFF);
    rd(11'h058); rd(11'h7FC); rd(11'h000);
    rd(11'h050); rd(11'h080); rd(11'h088);

    // R10: soft reset with same-cycle write and pulse
    tag = "R10";
    wr(11'h050, 32'hFFFF_FFFF);
    wr(11'h088, 32'hFFFF_FFFF);
    cyc(1, 0, 11'h080, 32'hFFFF_FFFF, 32'h0000_00FF, 1);
    idle();
    tag = "R6"; rd(11'h050); rd(11'h080); rd(11'h088);

    // R8: mask clear drops the interrupt
    tag = "R8";
    wr(11'h088, 32'h0000_0003);
    wr(11'h080, 32'h0000_0002);
    idle();
    wr(11'h08C, 32'h0000_0002);
    idle(); rd(11'h084);

    // R6: global reset mid-run clears sticky bits too
    tag = "R6";
    @(negedge clk); #1 grst_n = 1'b0;
    idle(); idle();
    @(negedge clk); #1 grst_n = 1'b1;
    idle(); rd(11'h050); rd(11'h080);
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule